// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break Handling

This block receives asynchronous serial frames on a single input line, oversampled by a baud tick that pulses sixteen times per bit period. Each frame is a low start bit, eight data bits sent least-significant first, an optional even or odd parity bit, and one high stop bit. A completed byte is presented on a data output with a data-ready level that stays set until the consumer acknowledges it.

Three sticky error bits record framing, parity and overrun conditions. Only an explicit per-bit clear pulse removes them. The synchronized level of the receive line is available directly. Software can therefore separate a line break (the line held at 0) from an isolated framing error (the line back at 1). During a break the receiver keeps timing frames, so it raises a framing error again for every frame period the line stays low. It does not mistake the held-low line for new start bits.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset, `data_valid` is 0, `err_flags` is 3'b000 and `line_level` is 1.
- R2: A frame with a valid start bit and a high stop bit delivers its eight data bits, least-significant first, on `data_out` and sets `data_valid`.
- R3: With `par_en`=1 the bit after the data is checked as parity: even when `par_odd`=0, odd when `par_odd`=1. A mismatch sets `err_flags[1]`. The byte is still delivered.
- R4: A low pulse shorter than half a bit period (8 baud ticks) is rejected as a false start. No byte and no flag result.
- R5: A stop bit sampled as 0 sets `err_flags[0]` and delivers no byte.
- R6: While the line is held low, `err_flags[0]` is set again once per frame period after it is cleared. With odd parity enabled, `err_flags[1]` is set as well.
- R7: A held-low line is never taken as a series of new start bits. Once the line returns high, the next frame is received normally.
- R8: `line_level` follows `rxd` after the synchronizer delay, whether or not reception is enabled.
- R9: If a frame completes while `data_valid` is still set, `err_flags[2]` is set and the older byte stays on `data_out`.
- R10: A `data_ack` pulse clears `data_valid`.
- R11: `err_clr` bit n clears only `err_flags` bit n. A flag never drops without its clear bit.
- R12: With `rx_en`=0 no frame is received, and the error flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rxd | input | 1 | Serial receive line, idle high |
| data_ack | input | 1 | Consumer has taken the byte |
| err_clr | input | 3 | Per-flag clear pulse (bit 0 frame, 1 parity, 2 overrun) |
| data_valid | output | 1 | Byte pending on data_out |
| data_out | output | 8 | Received byte |
| err_flags | output | 3 | Sticky flags: bit 0 framing, bit 1 parity, bit 2 overrun |
| line_level | output | 1 | Synchronized level of rxd |

## Verification
Frames are sent in a range of shapes: no parity, correct even and correct odd parity, a deliberately flipped parity bit, a low stop bit, and an all-zero frame with both faults. These shapes separate the data path from each error source. A sub-half-bit low glitch tells a real start bit apart from noise. Holding the line low across several frame periods, with and without odd parity, shows that the framing error returns after a clear and that no byte is produced. A normal frame after the break shows that reception recovers. Back-to-back frames without an acknowledge exercise overrun, and traffic while reception is disabled shows that the flags persist.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  localparam int FLAG_FRAME   = 0;
  localparam int FLAG_PARITY  = 1;
  localparam int FLAG_OVERRUN = 2;
  localparam int NUM_FLAGS    = 3;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      // a set in the same cycle as a clear wins
      always_comb flag_d[i] = set[i] | (flag_q[i] & ~clr[i]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[i] <= 1'b0;
        else        flag_q[i] <= flag_d[i];
      end
    end
  endgenerate

  assign q = flag_q;

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic                 tick,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 rxs,
  output logic                 frame_done,
  output logic                 frame_stop_ok,
  output logic                 frame_par_err,
  output logic [DATA_BITS-1:0] frame_data
);

  localparam int CW        = $clog2(OSR);
  localparam int BW        = $clog2(DATA_BITS);
  localparam int FT_NOPAR  = OSR * (DATA_BITS + 2);
  localparam int FT_PAR    = OSR * (DATA_BITS + 3);
  localparam int HW        = $clog2(FT_PAR + 1);
  localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

  rx_state_e            state_q, state_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [BW-1:0]        bit_q, bit_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 pbit_q, pbit_d;
  logic [HW-1:0]        hold_q, hold_d;
  logic [HW-1:0]        frame_last;
  logic [CW-1:0]        cnt_step;
  logic                 at_last;

  assign frame_last = par_en ? HW'(FT_PAR - 1) : HW'(FT_NOPAR - 1);
  assign at_last    = (cnt_q == LAST_CNT);
  assign cnt_step   = at_last ? '0 : cnt_q + 1'b1;

  always_comb begin
    state_d       = state_q;
    cnt_d         = cnt_q;
    bit_d         = bit_q;
    sh_d          = sh_q;
    pbit_d        = pbit_q;
    hold_d        = hold_q;
    frame_done    = 1'b0;
    frame_stop_ok = 1'b0;
    frame_par_err = 1'b0;
    frame_data    = sh_q;

    if (!rx_en) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (tick && !rxs) begin
            state_d = ST_START;
            cnt_d   = '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (cnt_q == MID_CNT) begin
              cnt_d = '0;
              if (!rxs) begin
                state_d = ST_DATA;
                bit_d   = '0;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            cnt_d = cnt_step;
            if (at_last) begin
              sh_d = {rxs, sh_q[DATA_BITS-1:1]};
              if (bit_q == LAST_BIT) begin
                state_d = par_en ? ST_PARITY : ST_STOP;
              end else begin
                bit_d = bit_q + 1'b1;
              end
            end
          end
        end
        ST_PARITY: begin
          if (tick) begin
            cnt_d = cnt_step;
            if (at_last) begin
              pbit_d  = rxs;
              state_d = ST_STOP;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            cnt_d = cnt_step;
            if (at_last) begin
              frame_done    = 1'b1;
              frame_stop_ok = rxs;
              frame_par_err = par_en & ((^sh_q ^ pbit_q) != par_odd);
              if (rxs) begin
                state_d = ST_IDLE;
              end else begin
                state_d = ST_HOLD;
                hold_d  = '0;
              end
            end
          end
        end
        ST_HOLD: begin
          // line held low after a bad stop bit: count whole break frames
          if (rxs) begin
            state_d = ST_IDLE;
          end else if (tick) begin
            if (hold_q == frame_last) begin
              hold_d        = '0;
              frame_done    = 1'b1;
              frame_stop_ok = 1'b0;
              frame_par_err = par_en & par_odd;
              frame_data    = '0;
            end else begin
              hold_d = hold_q + 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      pbit_q  <= pbit_d;
      hold_q  <= hold_d;
    end
  end

endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic                 baud_tick,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 rxd,
  input  logic                 data_ack,
  input  logic [NUM_FLAGS-1:0] err_clr,
  output logic                 data_valid,
  output logic [DATA_BITS-1:0] data_out,
  output logic [NUM_FLAGS-1:0] err_flags,
  output logic                 line_level
);

  logic                 rxs;
  logic                 done;
  logic                 stop_ok;
  logic                 par_err;
  logic [DATA_BITS-1:0] fdata;
  logic                 load;
  logic                 dv_q, dv_d;
  logic [DATA_BITS-1:0] data_q;
  logic [NUM_FLAGS-1:0] flag_set;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rxd),
    .dout  (rxs)
  );

  uart_rx_core #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_en         (rx_en),
    .tick          (baud_tick),
    .par_en        (par_en),
    .par_odd       (par_odd),
    .rxs           (rxs),
    .frame_done    (done),
    .frame_stop_ok (stop_ok),
    .frame_par_err (par_err),
    .frame_data    (fdata)
  );

  assign load = done & stop_ok & ~dv_q;
  assign dv_d = load | (dv_q & ~data_ack);

  always_comb begin
    flag_set               = '0;
    flag_set[FLAG_FRAME]   = done & ~stop_ok;
    flag_set[FLAG_PARITY]  = done & par_err;
    flag_set[FLAG_OVERRUN] = done & stop_ok & dv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dv_q <= 1'b0;
    else        dv_q <= dv_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= fdata;
  end

  uart_rx_flags #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (err_clr),
    .q     (err_flags)
  );

  assign data_valid = dv_q;
  assign data_out   = data_q;
  assign line_level = rxs;

endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          data_ack,
  input logic [2:0]    err_clr,
  input logic          data_valid,
  input logic [DW-1:0] data_out,
  input logic [2:0]    err_flags
);

  // flags drop only where the matching clear bit was pulsed (also covers R12)
  assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(err_flags) & ~err_flags) & ~$past(err_clr)) == 3'b000));

  assert_no_rx_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_en) |-> !$rose(data_valid));

  assert_pending_byte_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && $past(data_valid)) |-> $stable(data_out));

  assert_overrun_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[2]) |-> $past(data_valid));

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && data_ack) |=> !data_valid);

  assert_frame_err_no_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[0]) |-> !$rose(data_valid));

endmodule

bind uart_rx_brk uart_rx_brk_chk #(.DW(DATA_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .data_ack   (data_ack),
  .err_clr    (err_clr),
  .data_valid (data_valid),
  .data_out   (data_out),
  .err_flags  (err_flags)
);

// File: tb/uart_rx_brk_tb.sv
module uart_rx_brk_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OSR        = 16;
  localparam int BIT_CLKS   = TICK_DIV * OSR;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 6;

  // {data[14:7], par_en, par_odd, flip_parity, stop, exp_valid, exp_frame, exp_parity}
  localparam logic [14:0] VEC [NVEC] = '{
    {8'hA5, 7'b0001100},
    {8'h3C, 7'b1001100},
    {8'h3C, 7'b1101100},
    {8'h81, 7'b1011101},
    {8'h7E, 7'b0000010},
    {8'h00, 7'b1110011}
  };

  logic       clk;
  logic       rst_n;
  logic       rx_en;
  logic       baud_tick;
  logic       par_en;
  logic       par_odd;
  logic       rxd;
  logic       data_ack;
  logic [2:0] err_clr;
  logic       data_valid;
  logic [7:0] data_out;
  logic [2:0] err_flags;
  logic       line_level;

  int  n_chk;
  int  n_fail;
  bit  finished;

  uart_rx_brk u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .baud_tick  (baud_tick),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .rxd        (rxd),
    .data_ack   (data_ack),
    .err_clr    (err_clr),
    .data_valid (data_valid),
    .data_out   (data_out),
    .err_flags  (err_flags),
    .line_level (line_level)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    baud_tick = 1'b0;
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit pe, input bit po,
                            input bit flip, input bit stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (pe) send_bit((po ? ~^d : ^d) ^ flip);
    send_bit(stop);
    rxd = 1'b1;
  endtask

  task automatic pulse_clr(input logic [2:0] m);
    @(negedge clk);
    err_clr = m;
    @(negedge clk);
    err_clr = 3'b000;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    data_ack = 1'b1;
    @(negedge clk);
    data_ack = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [14:0] v;
    n_chk    = 0;
    n_fail   = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    rx_en    = 1'b0;
    par_en   = 1'b0;
    par_odd  = 1'b0;
    rxd      = 1'b1;
    data_ack = 1'b0;
    err_clr  = 3'b000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 data_valid", int'(data_valid), 0);
    check("R1 err_flags", int'(err_flags), 0);
    check("R1 line_level", int'(line_level), 1);

    // R8 line level visible while disabled
    rxd = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 line_level low", int'(line_level), 0);
    rxd = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 line_level high", int'(line_level), 1);

    rx_en = 1'b1;
    wait_bits(1);

    // vector table: R2 data, R3 parity, R5 framing
    for (int i = 0; i < NVEC; i++) begin
      v       = VEC[i];
      par_en  = v[6];
      par_odd = v[5];
      pulse_clr(3'b111);
      if (data_valid) pulse_ack();
      wait_bits(1);
      send_frame(v[14:7], v[6], v[5], v[4], v[3]);
      wait_bits(1);
      check("R2 data_valid", int'(data_valid), int'(v[2]));
      if (v[2]) check("R2 data_out", int'(data_out), int'(v[14:7]));
      check("R5 frame flag", int'(err_flags[0]), int'(v[1]));
      check("R3 parity flag", int'(err_flags[1]), int'(v[0]));
    end

    // R10 acknowledge
    pulse_clr(3'b111);
    if (!data_valid) begin
      send_frame(8'h44, 1'b0, 1'b0, 1'b0, 1'b1);
      wait_bits(1);
    end
    par_en = 1'b0;
    pulse_ack();
    check("R10 data_valid after ack", int'(data_valid), 0);

    // R4 short glitch
    rxd = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rxd = 1'b1;
    wait_bits(12);
    check("R4 glitch no byte", int'(data_valid), 0);
    check("R4 glitch no flag", int'(err_flags), 0);

    // R9 overrun
    send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b1);
    wait_bits(1);
    send_frame(8'h22, 1'b0, 1'b0, 1'b0, 1'b1);
    wait_bits(1);
    check("R9 overrun flag", int'(err_flags[2]), 1);
    check("R9 old byte kept", int'(data_out), 8'h11);
    check("R9 still valid", int'(data_valid), 1);
    pulse_ack();
    check("R10 ack after overrun", int'(data_valid), 0);

    // R12 disabled receiver keeps flags, receives nothing
    rx_en = 1'b0;
    wait_bits(1);
    check("R12 flags kept", int'(err_flags), 3'b100);
    send_frame(8'h33, 1'b0, 1'b0, 1'b0, 1'b1);
    wait_bits(1);
    check("R12 no byte while disabled", int'(data_valid), 0);
    rx_en = 1'b1;
    pulse_clr(3'b111);
    check("R11 all cleared", int'(err_flags), 0);
    wait_bits(1);

    // R6 / R7 break, no parity (frame = 10 bits)
    rxd = 1'b0;
    wait_bits(11);
    check("R6 break frame flag", int'(err_flags[0]), 1);
    check("R6 break no parity flag", int'(err_flags[1]), 0);
    pulse_clr(3'b001);
    wait_bits(1);
    check("R6 frame flag cleared", int'(err_flags[0]), 0);
    wait_bits(9);
    check("R6 frame flag returns", int'(err_flags[0]), 1);
    check("R7 no byte during break", int'(data_valid), 0);
    check("R8 line_level in break", int'(line_level), 0);
    rxd = 1'b1;
    wait_bits(2);
    send_frame(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1);
    wait_bits(1);
    check("R7 recovery valid", int'(data_valid), 1);
    check("R7 recovery data", int'(data_out), 8'h5A);
    pulse_ack();

    // R6 break with odd parity (frame = 11 bits)
    par_en  = 1'b1;
    par_odd = 1'b1;
    pulse_clr(3'b111);
    rxd = 1'b0;
    wait_bits(12);
    check("R6 odd break flags", int'(err_flags), 3'b011);
    pulse_clr(3'b011);
    wait_bits(12);
    check("R6 odd break flags again", int'(err_flags), 3'b011);
    pulse_clr(3'b010);
    check("R11 parity only cleared", int'(err_flags), 3'b001);
    rxd = 1'b1;
    wait_bits(2);
    send_frame(8'hC3, 1'b1, 1'b1, 1'b0, 1'b1);
    wait_bits(1);
    check("R7 odd recovery valid", int'(data_valid), 1);
    check("R7 odd recovery data", int'(data_out), 8'hC3);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule